// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging only by its 48-bit destination address. Software loads a station address, a 64-bin multicast hash table and three mode bits through a simple write port. The receive path delivers the destination address as six bytes on a byte-wide stream, with the first byte marked by a start-of-frame strobe. One clock after the sixth byte is taken, the block pulses a verdict for one cycle, saying whether the frame is accepted or rejected.

Unicast destinations are compared exactly against the station address. Multicast destinations, broadcast included, are either passed wholesale, looked up in the hash table, or rejected, depending on the mode bits. The hash index is the top six bits of a CRC-32 computed over the six address bytes. Promiscuous mode overrides everything and accepts all frames. Configuration is written into staging registers and copied into the working set at each start of frame, so a frame is always judged against one consistent configuration.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, verdict_valid is 0, the station address, both table words and all mode bits are 0, and no verdict appears until a full address has been received.
- R2: Address bytes are taken on clock edges where byte_valid is 1. The first byte needs sof=1 alongside byte_valid=1. The destination is byte 0 (the sof byte) in bits 7:0 of the address, up to byte 5 in bits 47:40. Idle cycles with byte_valid=0 may appear between bytes. verdict_valid is 1 in exactly the one cycle after the edge that takes the sixth byte, and is 0 in every other cycle.
- R3: The write port selects a register with cfg_sel. 0 is station address bits 31:0. 1 is station address bits 47:32, taken from wdata[15:0]. 2 is the low table word, holding bins 0 to 31. 3 is the high table word, holding bins 32 to 63. 4 is the mode register, where bit 0 is promiscuous, bit 1 is pass-all-multicast and bit 2 is hash mode.
- R4: With the promiscuous bit set, every frame is accepted whatever its address.
- R5: A destination is multicast when bit 0 of its first byte is 1, and this includes broadcast. With pass-all-multicast set, every multicast frame is accepted without a table lookup.
- R6: The hash index is bits 31:26 of a CRC-32 using polynomial 0x04C11DB7, with the register preset to 0xFFFFFFFF and each byte shifted in least significant bit first. The register is neither reflected nor complemented. The top index bit picks the word: 0 picks the low word and 1 picks the high word. The lower five bits pick the bit within that word. In hash mode a multicast frame is accepted only when that table bit is 1, so all-ones in both words accepts every multicast address.
- R7: Outside promiscuous mode, a unicast frame is accepted only when its destination equals the station address in all 48 bits.
- R8: With none of the three mode bits set, every multicast frame is rejected.
- R9: A new sof with byte_valid discards any partly received address and CRC state. The verdict then reflects only the new six bytes, and the abandoned frame produces no verdict.
- R10: Register writes take effect from the next start of frame. A write made while an address is being collected, or in the same cycle as sof, does not change the verdict of the frame in progress.
- R11: Bytes that arrive outside a frame are ignored and produce no verdict. This covers bytes before any sof and bytes after the sixth one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (R3) |
| cfg_wdata | input | 32 | Register write data |
| sof | input | 1 | Marks the first destination byte |
| byte_valid | input | 1 | Address byte present on byte_data |
| byte_data | input | 8 | Destination address byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Accept (1) or reject (0), meaningful while verdict_valid is 1 |

## Verification
The hardest case to reach from the ports is a multicast address whose hash lands on one particular table bin. With random addresses and random tables, a wrong word choice or a wrong bit order would often go unnoticed. The bench therefore computes each address's bin with its own bit-serial CRC. It then loads a table holding only that bin, and then a table with every bin except that one, so the verdict depends on that single bit alone. Frames cut short by a fresh sof, and writes placed in the middle of an address, are driven directly. Random frames with random gaps are mixed in, and their addresses are drawn from the station address, broadcast and random values.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  localparam logic [2:0] SEL_STA_LO  = 3'd0;
  localparam logic [2:0] SEL_STA_HI  = 3'd1;
  localparam logic [2:0] SEL_HASH_LO = 3'd2;
  localparam logic [2:0] SEL_HASH_HI = 3'd3;
  localparam logic [2:0] SEL_MODE    = 3'd4;

  typedef struct packed {
    logic hash_mode;   // bit 2
    logic all_mcast;   // bit 1
    logic promisc;     // bit 0
  } filt_mode_t;

  // Shift one byte into the CRC register, least significant bit first.
  function automatic logic [31:0] crc_add_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ data[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dfilt_cfg_regs.sv
module dfilt_cfg_regs
  import dfilt_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int WORD_W  = 32,
  parameter int TABLE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               snap_en,
  output logic [ADDR_W-1:0]  sta_act,
  output logic [TABLE_W-1:0] tbl_act,
  output filt_mode_t         mode_act
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [ADDR_W-1:0]  sta_stg;
  logic [TABLE_W-1:0] tbl_stg;
  filt_mode_t         mode_stg;

  // Staging registers: software writes land here at any time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_stg  <= '0;
      tbl_stg  <= '0;
      mode_stg <= '0;
    end else if (we) begin
      case (sel)
        SEL_STA_LO:  sta_stg[WORD_W-1:0]       <= wdata;
        SEL_STA_HI:  sta_stg[ADDR_W-1:WORD_W]  <= wdata[HI_W-1:0];
        SEL_HASH_LO: tbl_stg[WORD_W-1:0]       <= wdata;
        SEL_HASH_HI: tbl_stg[TABLE_W-1:WORD_W] <= wdata;
        SEL_MODE: begin
          mode_stg.promisc   <= wdata[0];
          mode_stg.all_mcast <= wdata[1];
          mode_stg.hash_mode <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  // Working copy: refreshed only when a frame starts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_act  <= '0;
      tbl_act  <= '0;
      mode_act <= '0;
    end else if (snap_en) begin
      sta_act  <= sta_stg;
      tbl_act  <= tbl_stg;
      mode_act <= mode_stg;
    end
  end

  AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> ($stable(sta_act) && $stable(tbl_act) && $stable(mode_act))); // R10

endmodule

// File: rtl/dfilt_addr_collect.sv
module dfilt_addr_collect
  import dfilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  output logic                    frame_start,
  output logic [ADDR_BYTES*8-1:0] addr_q,
  output logic [31:0]             crc_q,
  output logic                    addr_done
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int CNT_W  = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic             collecting;
  logic [CNT_W-1:0] cnt;
  logic             byte_take;
  logic             last_take;

  assign frame_start = sof && byte_valid;
  assign byte_take   = collecting && byte_valid && !sof;
  assign last_take   = byte_take && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      cnt        <= '0;
      addr_q     <= '0;
      crc_q      <= CRC_SEED;
      addr_done  <= 1'b0;
    end else begin
      addr_done <= last_take;
      if (frame_start) begin
        collecting  <= 1'b1;
        cnt         <= CNT_W'(1);
        addr_q      <= '0;
        addr_q[7:0] <= byte_data;
        crc_q       <= crc_add_byte(CRC_SEED, byte_data);
      end else if (byte_take) begin
        addr_q[cnt*8 +: 8] <= byte_data;
        crc_q              <= crc_add_byte(crc_q, byte_data);
        cnt                <= cnt + CNT_W'(1);
        if (cnt == LAST_IDX) collecting <= 1'b0;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    collecting |-> (cnt != '0 && cnt <= LAST_IDX)); // R2
  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> !collecting); // R11

  logic unused_ok;
  assign unused_ok = ^{ADDR_W{1'b0}};

endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide
  import dfilt_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int TABLE_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       addr_done,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                crc,
  input  logic [ADDR_W-1:0]          sta,
  input  logic [TABLE_W-1:0]         tbl,
  input  filt_mode_t                 mode,
  output logic                       accept
);
  localparam int IDX_W = $clog2(TABLE_W);

  logic             is_mcast;
  logic [IDX_W-1:0] hash_idx;
  logic             hash_hit;
  logic             sta_hit;

  assign is_mcast = addr[0];
  assign hash_idx = crc[31 -: IDX_W];
  assign hash_hit = tbl[hash_idx];
  assign sta_hit  = (addr == sta);

  always_comb begin
    if (mode.promisc)       accept = 1'b1;
    else if (!is_mcast)     accept = sta_hit;
    else if (mode.all_mcast) accept = 1'b1;
    else if (mode.hash_mode) accept = hash_hit;
    else                    accept = 1'b0;
  end

  AST_PROMISC_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && mode.promisc) |-> accept); // R4
  AST_NO_MODE_MCAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && is_mcast && mode == '0) |-> !accept); // R8
  AST_UCAST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !is_mcast && !mode.promisc && accept) |-> sta_hit); // R7

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import dfilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              sof,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              verdict_valid,
  output logic              verdict_accept
);
  localparam int ADDR_W  = ADDR_BYTES * 8;
  localparam int TABLE_W = 2 * WORD_W;

  logic               frame_start;
  logic [ADDR_W-1:0]  addr_q;
  logic [31:0]        crc_q;
  logic               addr_done;
  logic [ADDR_W-1:0]  sta_act;
  logic [TABLE_W-1:0] tbl_act;
  filt_mode_t         mode_act;
  logic               accept;

  dfilt_cfg_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TABLE_W(TABLE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .snap_en(frame_start), .sta_act(sta_act), .tbl_act(tbl_act), .mode_act(mode_act)
  );

  dfilt_addr_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_start(frame_start), .addr_q(addr_q),
    .crc_q(crc_q), .addr_done(addr_done)
  );

  dfilt_decide #(.ADDR_W(ADDR_W), .TABLE_W(TABLE_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .addr_done(addr_done), .addr(addr_q), .crc(crc_q),
    .sta(sta_act), .tbl(tbl_act), .mode(mode_act), .accept(accept)
  );

  assign verdict_valid  = addr_done;
  assign verdict_accept = addr_done && accept;

  AST_VERDICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid); // R2
  AST_VERDICT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(byte_valid)); // R2
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_accept |-> verdict_valid); // R2

endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sof = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        verdict_valid;
  logic        verdict_accept;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [47:0] m_sta = '0;
  logic [63:0] m_tbl = '0;
  logic [2:0]  m_mode = '0;

  always #2.5 clk = ~clk;

  rx_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept)
  );

  // Bit-serial CRC over the address as a 48-bit stream, bit 0 first.
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic top = c[31];
      c = c << 1;
      if (top != a[k]) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic bit ref_accept(input logic [47:0] a, input logic [47:0] s,
                                    input logic [63:0] t, input logic [2:0] m);
    logic [5:0] b;
    if (m[0]) return 1'b1;
    if (!a[0]) return (a == s);
    if (m[1]) return 1'b1;
    if (m[2]) begin
      b = ref_bin(a);
      return b[5] ? t[32 + b[4:0]] : t[b[4:0]];
    end
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      3'd0: m_sta[31:0]  = d;
      3'd1: m_sta[47:32] = d[15:0];
      3'd2: m_tbl[31:0]  = d;
      3'd3: m_tbl[63:32] = d;
      3'd4: m_mode       = d[2:0];
      default: ;
    endcase
  endtask

  // Sends six bytes; optional random gaps; optional register write at byte wr_at.
  // Returns the verdict sampled in the cycle after the sixth byte.
  task automatic send(input logic [47:0] a, input bit gaps, input int wr_at,
                      input logic [2:0] ws, input logic [31:0] wd,
                      output bit vv, output bit acc, output bit early);
    early = 0;
    for (int i = 0; i < 6; i++) begin
      if (gaps && i > 0) begin
        int g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          byte_valid = 1'b0; sof = 1'b0;
          @(negedge clk);
          if (verdict_valid) early = 1;
        end
      end
      sof = (i == 0); byte_valid = 1'b1; byte_data = a[i*8 +: 8];
      if (i == wr_at) begin cfg_we = 1'b1; cfg_sel = ws; cfg_wdata = wd; end
      @(negedge clk);
      cfg_we = 1'b0;
      if (i < 5 && verdict_valid) early = 1;
    end
    sof = 1'b0; byte_valid = 1'b0;
    vv = verdict_valid; acc = verdict_accept;
    @(negedge clk);
    if (verdict_valid) early = 1;
  endtask

  task automatic frame_check(input logic [47:0] a, input string req);
    bit vv, acc, early;
    bit exp = ref_accept(a, m_sta, m_tbl, m_mode);
    send(a, 1'b0, -1, 3'd0, 32'd0, vv, acc, early);
    check(vv && !early, {req, " R2 pulse"}, vv, 1);
    check(acc == exp, req, acc, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    bit vv, acc, early;
    logic [47:0] sta0 = 48'h5A_34_12_CD_AB_02;
    logic [47:0] mc0  = 48'h33_22_11_00_5E_01;
    logic [5:0]  b0;
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(verdict_valid == 0, "R1 idle", verdict_valid, 0);
    frame_check(48'h0, "R1 zero station matches zero unicast");
    frame_check(48'hFFFF_FFFF_FFFF, "R1 broadcast rejected at reset");

    // R11: bytes without sof
    for (int i = 0; i < 8; i++) begin byte_valid = 1; byte_data = 8'(i); @(negedge clk);
      if (verdict_valid) early = 1; end
    byte_valid = 0;
    check(!early, "R11 stray bytes", early, 0);

    // R3/R7: station address
    wr(3'd0, sta0[31:0]); wr(3'd1, {16'hFFFF, sta0[47:32]});
    frame_check(sta0, "R7 exact match");
    frame_check(sta0 ^ 48'h0100_0000_0000, "R7 top byte differs");
    frame_check(sta0 ^ 48'h0000_0000_0002, "R7 low byte differs");

    // R8: no mode, multicast dropped
    frame_check(mc0, "R8 multicast no mode");
    frame_check(48'hFFFF_FFFF_FFFF, "R8 broadcast no mode");

    // R5
    wr(3'd4, 32'h2);
    frame_check(mc0, "R5 pass all multicast");
    frame_check(48'hFFFF_FFFF_FFFF, "R5 broadcast");
    frame_check(sta0 ^ 48'h10, "R5 unicast still exact");

    // R6: single-bin tables
    wr(3'd4, 32'h4);
    b0 = ref_bin(mc0);
    wr(3'd2, b0[5] ? 32'h0 : (32'h1 << b0[4:0]));
    wr(3'd3, b0[5] ? (32'h1 << b0[4:0]) : 32'h0);
    frame_check(mc0, "R6 only its bin set");
    wr(3'd2, ~m_tbl[31:0]); wr(3'd3, ~m_tbl[63:32]);
    frame_check(mc0, "R6 all but its bin");
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 20; i++)
      frame_check({$urandom(), 16'($urandom()) | 16'h1}, "R6 all ones table");
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    frame_check(mc0, "R6 empty table");

    // R4
    wr(3'd4, 32'h1);
    frame_check(48'h0000_0000_0010, "R4 promiscuous unicast");
    frame_check(mc0, "R4 promiscuous multicast");

    // R9: abandoned partial frame
    wr(3'd4, 32'h0);
    early = 0;
    for (int i = 0; i < 3; i++) begin
      sof = (i == 0); byte_valid = 1; byte_data = 8'hEE; @(negedge clk);
      if (verdict_valid) early = 1;
    end
    check(!early, "R9 no verdict for partial", early, 0);
    frame_check(sta0, "R9 restart matches station");

    // R10: mid-frame write does not affect current frame
    send(48'h0000_0000_0020, 1'b0, 3, 3'd4, 32'h1, vv, acc, early);
    m_mode = 3'b001;
    check(vv && acc == 0, "R10 mid-frame promisc ignored", acc, 0);
    frame_check(48'h0000_0000_0020, "R10 next frame promisc");
    send(48'h0000_0000_0020, 1'b0, 0, 3'd4, 32'h0, vv, acc, early);
    m_mode = 3'b000;
    check(vv && acc == 1, "R10 write with sof ignored", acc, 1);
    frame_check(48'h0000_0000_0020, "R10 later frame no promisc");

    // R2/R11: gaps and trailing bytes
    send(sta0, 1'b1, -1, 3'd0, 32'd0, vv, acc, early);
    check(vv && acc && !early, "R2 gapped frame", acc, 1);
    early = 0;
    for (int i = 0; i < 4; i++) begin byte_valid = 1; byte_data = 8'h55; @(negedge clk);
      if (verdict_valid) early = 1; end
    byte_valid = 0;
    check(!early, "R11 trailing bytes", early, 0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [47:0] a;
      bit exp;
      int k = $urandom_range(0, 3);
      if ($urandom_range(0, 9) == 0) wr(3'd4, $urandom());
      if ($urandom_range(0, 9) == 0) wr(3'(2 + $urandom_range(0, 1)), $urandom());
      a = (k == 0) ? m_sta : (k == 1) ? 48'hFFFF_FFFF_FFFF : {$urandom(), 16'($urandom())};
      exp = ref_accept(a, m_sta, m_tbl, m_mode);
      send(a, 1'b1, -1, 3'd0, 32'd0, vv, acc, early);
      check(vv && !early && acc == exp, "R6 R7 random frame", acc, exp);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

endmodule